// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits between a host write port and the write state machine of a flash-style storage controller. Each host bus write arrives as a one-cycle strobe that carries a 20-bit address and a data byte. The decoder accepts keyed sequences of 3 or 6 writes, plus the single-write suspend and resume codes, and turns each accepted command into a one-cycle start pulse. For erase, program and lock commands it also latches the target address. It tracks which source the host reads from (array, status or identifier). It also keeps a context of what the write state machine is doing: idle, programming, chip erase, sector erase, suspended or lock update. This context narrows the set of commands it accepts. It refuses a command that the context does not allow, a lock change while write-protect is low, and a program or sector erase aimed at a protected sector. Each refusal gives a reject pulse.

The sequence tracker has seven named states. `SEQ_IDLE` waits for the first key. `SEQ_KEY1` follows AAh at 5555h. `SEQ_KEY2` follows 55h at 2AAAh and decodes the command byte. `SEQ_EXT0`, `SEQ_EXT1` and `SEQ_EXT2` cover the second key pair and the final byte of a 6-write sequence. `SEQ_LOAD` waits for the first page-load write after a program command. A transition either advances on a matching write (match), or falls back on any other write (restart). On a restart the same write is decoded again as a possible first write. The context register has these states: `CTX_IDLE`, `CTX_PROG`, `CTX_CERASE`, `CTX_SERASE`, `CTX_SUSP` and `CTX_LOCK`. Its transitions are: start (idle to a busy state), suspend (`CTX_SERASE` to `CTX_SUSP`), resume (`CTX_SUSP` to `CTX_SERASE`), done (a busy state to idle when the write state machine reports completion) and flush (power-down or reset).

Top module: `cmdseq_decoder`

## Requirements
- R1: A key write matches on the low 15 address bits only. The first key is data AAh at 5555h and the second key is data 55h at 2AAAh. Address bits 19..15 are ignored for key and command-address matching.
- R2: After both keys, a third write at 5555h decodes as follows. F0h sets read mode to array (rd_mode 2'b00). 90h sets identifier mode (2'b10). 70h sets status mode (2'b01). 50h gives a one-cycle status_clear pulse and leaves the read mode unchanged. Any other byte starts nothing.
- R3: After both keys and A0h at 5555h, the next write is taken as the first page load. If accepted, it gives start_prog, latches its full address on tgt_addr and sets status mode.
- R4: A 6-write erase is: 80h at 5555h, then both keys again, then one final write. A final 10h at 5555h gives start_chip_erase. A final 30h at any address gives start_sect_erase. Both latch the final write's address on tgt_addr.
- R5: A 6-write lock update uses the set-up byte 60h and a final 20h (protect) or 40h (unprotect) at the sector address. The sector is address bits 19..16. While wp_n is low the request gives cmd_reject and no start.
- R6: A single write of B0h at any address gives erase_suspend, but only during a sector erase. A single write of D0h at any address gives erase_resume, but only while suspended. Anywhere else each gives cmd_reject.
- R7: During program, chip erase and lock update, only read status is accepted. During sector erase, read status and suspend are accepted. While suspended, read array, read status and resume are accepted. Any other completed command gives cmd_reject and changes neither the read mode nor the context.
- R8: Any start, suspend or resume sets status mode. The read mode then holds until another command is accepted.
- R9: Reset and power-down (pd high) both return the block to array mode, idle context and an empty sequence.
- R10: A program or sector erase whose target sector has its bit set in prot_mask gives cmd_reject and no start. The context stays idle.
- R11: A write that does not continue the current sequence restarts it. The same write is then decoded as a possible first key or as a single-write code.
- R12: All outputs are registered. A pulse appears in the cycle after the edge that samples the write strobe and lasts one cycle. At most one pulse is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pd | input | 1 | Power-down, clears the decoder while high |
| wp_n | input | 1 | Write-protect, low blocks lock updates |
| prot_mask | input | 16 | Per-sector protect bits, indexed by address bits 19..16 |
| wr_valid | input | 1 | One-cycle strobe for a host bus write |
| wr_addr | input | 20 | Address of the host write |
| wr_data | input | 8 | Low data byte of the host write |
| wsm_done | input | 1 | Write state machine completion pulse |
| rd_mode | output | 2 | Read source: 00 array, 01 status, 10 identifier |
| start_prog | output | 1 | Page program start pulse |
| start_chip_erase | output | 1 | Chip erase start pulse |
| start_sect_erase | output | 1 | Sector erase start pulse |
| start_protect | output | 1 | Sector protect start pulse |
| start_unprotect | output | 1 | Sector unprotect start pulse |
| erase_suspend | output | 1 | Suspend request pulse |
| erase_resume | output | 1 | Resume request pulse |
| status_clear | output | 1 | Clear-status pulse |
| cmd_reject | output | 1 | A completed command was refused |
| tgt_addr | output | 20 | Latched target address of the last start |

## Verification
The bench targets two kinds of cases. The first is a restart: a repeated first key, or a suspend code in the middle of a sequence. A decoder that drops the write that broke the sequence would miss the command that write begins. The second is context gating: status reads while programming, suspend during a chip erase, and identifier reads while suspended. A decoder that gates loosely would switch the read mode or issue a start while the state machine is busy. Protected-sector and write-protect refusals are driven through full sequences. Each must show a reject and no start, and a later accepted identifier read confirms that the context stayed idle. Power-down and reset in the middle of a sequence must leave array mode and must not let the remaining key writes complete a stale command.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    localparam logic [7:0] KEY_BYTE_A     = 8'hAA;
    localparam logic [7:0] KEY_BYTE_B     = 8'h55;
    localparam logic [7:0] OP_READ_ARRAY  = 8'hF0;
    localparam logic [7:0] OP_READ_ID     = 8'h90;
    localparam logic [7:0] OP_READ_STAT   = 8'h70;
    localparam logic [7:0] OP_CLR_STAT    = 8'h50;
    localparam logic [7:0] OP_PROGRAM     = 8'hA0;
    localparam logic [7:0] OP_ERASE_SETUP = 8'h80;
    localparam logic [7:0] OP_LOCK_SETUP  = 8'h60;
    localparam logic [7:0] OP_CHIP        = 8'h10;
    localparam logic [7:0] OP_SECTOR      = 8'h30;
    localparam logic [7:0] OP_LOCK        = 8'h20;
    localparam logic [7:0] OP_UNLOCK      = 8'h40;
    localparam logic [7:0] OP_SUSPEND     = 8'hB0;
    localparam logic [7:0] OP_RESUME      = 8'hD0;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'b00,
        RD_STATUS = 2'b01,
        RD_ID     = 2'b10
    } rd_mode_t;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_RESET,
        CMD_ID,
        CMD_STATUS,
        CMD_CLEAR,
        CMD_PROG,
        CMD_CERASE,
        CMD_SERASE,
        CMD_PROT,
        CMD_UNPROT,
        CMD_SUSP,
        CMD_RESUME
    } cmd_t;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_KEY1,
        SEQ_KEY2,
        SEQ_EXT0,
        SEQ_EXT1,
        SEQ_EXT2,
        SEQ_LOAD
    } seq_t;

    typedef enum logic [2:0] {
        CTX_IDLE,
        CTX_PROG,
        CTX_CERASE,
        CTX_SERASE,
        CTX_SUSP,
        CTX_LOCK
    } ctx_t;

    typedef struct packed {
        logic reject;
        logic clear;
        logic resume;
        logic suspend;
        logic unprot;
        logic prot;
        logic serase;
        logic cerase;
        logic prog;
    } evt_t;

endpackage

// File: rtl/cmdseq_match.sv
module cmdseq_match #(
    parameter int ADDR_W = 20,
    parameter int KEY_W  = 15,
    parameter logic [KEY_W-1:0] KEY_ADDR_A = 15'h5555,
    parameter logic [KEY_W-1:0] KEY_ADDR_B = 15'h2AAA
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output logic              hit_first,
    output logic              hit_second,
    output logic              at_cmd_addr
);
    import cmdseq_pkg::*;

    logic [KEY_W-1:0] low_addr;

    assign low_addr    = addr[KEY_W-1:0];
    assign at_cmd_addr = (low_addr == KEY_ADDR_A);
    assign hit_first   = at_cmd_addr && (data == KEY_BYTE_A);
    assign hit_second  = (low_addr == KEY_ADDR_B) && (data == KEY_BYTE_B);

endmodule

// File: rtl/cmdseq_fsm.sv
module cmdseq_fsm (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                wr_valid,
    input  logic [7:0]          wr_data,
    input  logic                hit_first,
    input  logic                hit_second,
    input  logic                at_cmd_addr,
    output cmdseq_pkg::cmd_t    cmd
);
    import cmdseq_pkg::*;

    seq_t seq_q, seq_d;
    logic lock_q, lock_d;
    seq_t restart_seq;
    cmd_t restart_cmd;

    // Decode of a write that is not a continuation
    always_comb begin
        restart_seq = hit_first ? SEQ_KEY1 : SEQ_IDLE;
        restart_cmd = CMD_NONE;
        if (!hit_first) begin
            if (wr_data == OP_SUSPEND)
                restart_cmd = CMD_SUSP;
            else if (wr_data == OP_RESUME)
                restart_cmd = CMD_RESUME;
        end
    end

    // Next state and command output
    always_comb begin
        seq_d  = seq_q;
        lock_d = lock_q;
        cmd    = CMD_NONE;
        if (wr_valid) begin
            unique case (seq_q)
                SEQ_IDLE: begin
                    seq_d = restart_seq;
                    cmd   = restart_cmd;
                end
                SEQ_KEY1: begin
                    if (hit_second) begin
                        seq_d = SEQ_KEY2;
                    end else begin
                        seq_d = restart_seq;
                        cmd   = restart_cmd;
                    end
                end
                SEQ_KEY2: begin
                    seq_d = SEQ_IDLE;
                    if (at_cmd_addr && wr_data == OP_READ_ARRAY)
                        cmd = CMD_RESET;
                    else if (at_cmd_addr && wr_data == OP_READ_ID)
                        cmd = CMD_ID;
                    else if (at_cmd_addr && wr_data == OP_READ_STAT)
                        cmd = CMD_STATUS;
                    else if (at_cmd_addr && wr_data == OP_CLR_STAT)
                        cmd = CMD_CLEAR;
                    else if (at_cmd_addr && wr_data == OP_PROGRAM)
                        seq_d = SEQ_LOAD;
                    else if (at_cmd_addr && wr_data == OP_ERASE_SETUP) begin
                        seq_d  = SEQ_EXT0;
                        lock_d = 1'b0;
                    end else if (at_cmd_addr && wr_data == OP_LOCK_SETUP) begin
                        seq_d  = SEQ_EXT0;
                        lock_d = 1'b1;
                    end else begin
                        seq_d = restart_seq;
                        cmd   = restart_cmd;
                    end
                end
                SEQ_EXT0: begin
                    if (hit_first) begin
                        seq_d = SEQ_EXT1;
                    end else begin
                        seq_d = restart_seq;
                        cmd   = restart_cmd;
                    end
                end
                SEQ_EXT1: begin
                    if (hit_second) begin
                        seq_d = SEQ_EXT2;
                    end else begin
                        seq_d = restart_seq;
                        cmd   = restart_cmd;
                    end
                end
                SEQ_EXT2: begin
                    seq_d = SEQ_IDLE;
                    if (!lock_q && at_cmd_addr && wr_data == OP_CHIP)
                        cmd = CMD_CERASE;
                    else if (!lock_q && wr_data == OP_SECTOR)
                        cmd = CMD_SERASE;
                    else if (lock_q && wr_data == OP_LOCK)
                        cmd = CMD_PROT;
                    else if (lock_q && wr_data == OP_UNLOCK)
                        cmd = CMD_UNPROT;
                    else begin
                        seq_d = restart_seq;
                        cmd   = restart_cmd;
                    end
                end
                SEQ_LOAD: begin
                    seq_d = SEQ_IDLE;
                    cmd   = CMD_PROG;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            seq_q  <= SEQ_IDLE;
            lock_q <= 1'b0;
        end else begin
            seq_q  <= seq_d;
            lock_q <= lock_d;
        end
    end

endmodule

// File: rtl/cmdseq_gate.sv
module cmdseq_gate #(
    parameter int ADDR_W = 20,
    parameter int SECT_W = 4,
    localparam int NSECT = 1 << SECT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  cmdseq_pkg::cmd_t        cmd,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic                    wp_n,
    input  logic [NSECT-1:0]        prot_mask,
    input  logic                    wsm_done,
    output cmdseq_pkg::evt_t        evt_q,
    output cmdseq_pkg::rd_mode_t    mode_q,
    output logic [ADDR_W-1:0]       tgt_q
);
    import cmdseq_pkg::*;

    ctx_t              ctx_q, ctx_d;
    evt_t              evt_d;
    rd_mode_t          mode_d;
    logic [ADDR_W-1:0] tgt_d;
    logic [SECT_W-1:0] sector;
    logic              sect_locked;
    logic              idle;
    logic              busy;
    logic              ok;

    assign sector      = wr_addr[ADDR_W-1 -: SECT_W];
    assign sect_locked = prot_mask[sector];
    assign idle        = (ctx_q == CTX_IDLE);
    assign busy        = (ctx_q == CTX_PROG) || (ctx_q == CTX_CERASE) ||
                         (ctx_q == CTX_SERASE) || (ctx_q == CTX_LOCK);

    // Permission, context transitions and next outputs
    always_comb begin
        ctx_d  = ctx_q;
        evt_d  = '0;
        mode_d = mode_q;
        tgt_d  = tgt_q;
        ok     = 1'b0;
        if (wsm_done && busy)
            ctx_d = CTX_IDLE;
        unique case (cmd)
            CMD_NONE: ;
            CMD_RESET: begin
                if (idle || ctx_q == CTX_SUSP) begin
                    ok     = 1'b1;
                    mode_d = RD_ARRAY;
                end
            end
            CMD_ID: begin
                if (idle) begin
                    ok     = 1'b1;
                    mode_d = RD_ID;
                end
            end
            CMD_STATUS: begin
                ok     = 1'b1;
                mode_d = RD_STATUS;
            end
            CMD_CLEAR: begin
                if (idle) begin
                    ok          = 1'b1;
                    evt_d.clear = 1'b1;
                end
            end
            CMD_PROG: begin
                if (idle && !sect_locked) begin
                    ok         = 1'b1;
                    evt_d.prog = 1'b1;
                    mode_d     = RD_STATUS;
                    tgt_d      = wr_addr;
                    ctx_d      = CTX_PROG;
                end
            end
            CMD_CERASE: begin
                if (idle) begin
                    ok           = 1'b1;
                    evt_d.cerase = 1'b1;
                    mode_d       = RD_STATUS;
                    tgt_d        = wr_addr;
                    ctx_d        = CTX_CERASE;
                end
            end
            CMD_SERASE: begin
                if (idle && !sect_locked) begin
                    ok           = 1'b1;
                    evt_d.serase = 1'b1;
                    mode_d       = RD_STATUS;
                    tgt_d        = wr_addr;
                    ctx_d        = CTX_SERASE;
                end
            end
            CMD_PROT, CMD_UNPROT: begin
                if (idle && wp_n) begin
                    ok           = 1'b1;
                    evt_d.prot   = (cmd == CMD_PROT);
                    evt_d.unprot = (cmd == CMD_UNPROT);
                    mode_d       = RD_STATUS;
                    tgt_d        = wr_addr;
                    ctx_d        = CTX_LOCK;
                end
            end
            CMD_SUSP: begin
                if (ctx_q == CTX_SERASE) begin
                    ok            = 1'b1;
                    evt_d.suspend = 1'b1;
                    mode_d        = RD_STATUS;
                    ctx_d         = CTX_SUSP;
                end
            end
            CMD_RESUME: begin
                if (ctx_q == CTX_SUSP) begin
                    ok           = 1'b1;
                    evt_d.resume = 1'b1;
                    mode_d       = RD_STATUS;
                    ctx_d        = CTX_SERASE;
                end
            end
            default: ;
        endcase
        if (cmd != CMD_NONE && !ok)
            evt_d.reject = 1'b1;
    end

    // Context register
    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            ctx_q <= CTX_IDLE;
        else
            ctx_q <= ctx_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            evt_q  <= '0;
            mode_q <= RD_ARRAY;
            tgt_q  <= '0;
        end else begin
            evt_q  <= evt_d;
            mode_q <= mode_d;
            tgt_q  <= tgt_d;
        end
    end

endmodule

// File: rtl/cmdseq_decoder.sv
module cmdseq_decoder #(
    parameter int ADDR_W = 20,
    parameter int KEY_W  = 15,
    parameter int SECT_W = 4,
    localparam int NSECT = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd,
    input  logic              wp_n,
    input  logic [NSECT-1:0]  prot_mask,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              wsm_done,
    output logic [1:0]        rd_mode,
    output logic              start_prog,
    output logic              start_chip_erase,
    output logic              start_sect_erase,
    output logic              start_protect,
    output logic              start_unprotect,
    output logic              erase_suspend,
    output logic              erase_resume,
    output logic              status_clear,
    output logic              cmd_reject,
    output logic [ADDR_W-1:0] tgt_addr
);
    import cmdseq_pkg::*;

    logic     hit_first;
    logic     hit_second;
    logic     at_cmd_addr;
    logic     wr_take;
    cmd_t     cmd;
    evt_t     evt;
    rd_mode_t mode;

    assign wr_take = wr_valid && !pd;

    cmdseq_match #(
        .ADDR_W (ADDR_W),
        .KEY_W  (KEY_W)
    ) u_match (
        .addr        (wr_addr),
        .data        (wr_data),
        .hit_first   (hit_first),
        .hit_second  (hit_second),
        .at_cmd_addr (at_cmd_addr)
    );

    cmdseq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (pd),
        .wr_valid    (wr_take),
        .wr_data     (wr_data),
        .hit_first   (hit_first),
        .hit_second  (hit_second),
        .at_cmd_addr (at_cmd_addr),
        .cmd         (cmd)
    );

    cmdseq_gate #(
        .ADDR_W (ADDR_W),
        .SECT_W (SECT_W)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (pd),
        .cmd       (cmd),
        .wr_addr   (wr_addr),
        .wp_n      (wp_n),
        .prot_mask (prot_mask),
        .wsm_done  (wsm_done),
        .evt_q     (evt),
        .mode_q    (mode),
        .tgt_q     (tgt_addr)
    );

    assign rd_mode          = mode;
    assign start_prog       = evt.prog;
    assign start_chip_erase = evt.cerase;
    assign start_sect_erase = evt.serase;
    assign start_protect    = evt.prot;
    assign start_unprotect  = evt.unprot;
    assign erase_suspend    = evt.suspend;
    assign erase_resume     = evt.resume;
    assign status_clear     = evt.clear;
    assign cmd_reject       = evt.reject;

endmodule

// File: rtl/cmdseq_checker.sv
module cmdseq_checker #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pd,
    input logic              wp_n,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic [1:0]        rd_mode,
    input logic              start_prog,
    input logic              start_chip_erase,
    input logic              start_sect_erase,
    input logic              start_protect,
    input logic              start_unprotect,
    input logic              erase_suspend,
    input logic              erase_resume,
    input logic              status_clear,
    input logic              cmd_reject,
    input logic [ADDR_W-1:0] tgt_addr
);
    logic [8:0] pulses;
    logic       any_start;

    assign pulses = {cmd_reject, status_clear, erase_resume, erase_suspend,
                     start_unprotect, start_protect, start_sect_erase,
                     start_chip_erase, start_prog};
    assign any_start = start_prog | start_chip_erase | start_sect_erase |
                       start_protect | start_unprotect;

    assert_one_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulses));

    assert_pulse_follows_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulses) |-> $past(wr_valid));

    assert_lock_needs_wp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_protect || start_unprotect) |-> $past(wp_n));

    assert_start_shows_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (any_start || erase_suspend || erase_resume) |-> (rd_mode == 2'b01));

    assert_pd_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pd) |-> (rd_mode == 2'b00 && pulses == 9'd0));

    assert_suspend_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_suspend |-> ($past(wr_data) == 8'hB0));

    assert_resume_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_resume |-> ($past(wr_data) == 8'hD0));

    assert_prog_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_prog |-> (tgt_addr == $past(wr_addr)));

endmodule

bind cmdseq_decoder cmdseq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .pd               (pd),
    .wp_n             (wp_n),
    .wr_valid         (wr_valid),
    .wr_addr          (wr_addr),
    .wr_data          (wr_data),
    .rd_mode          (rd_mode),
    .start_prog       (start_prog),
    .start_chip_erase (start_chip_erase),
    .start_sect_erase (start_sect_erase),
    .start_protect    (start_protect),
    .start_unprotect  (start_unprotect),
    .erase_suspend    (erase_suspend),
    .erase_resume     (erase_resume),
    .status_clear     (status_clear),
    .cmd_reject       (cmd_reject),
    .tgt_addr         (tgt_addr)
);

// File: tb/sim_cmdseq_decoder.sv
`timescale 1ns/1ps
module sim_cmdseq_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pd = 1'b0;
    logic        wp_n = 1'b1;
    logic [15:0] prot_mask = 16'h0008;
    logic        wr_valid = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wsm_done = 1'b0;
    logic [1:0]  rd_mode;
    logic        start_prog, start_chip_erase, start_sect_erase;
    logic        start_protect, start_unprotect, erase_suspend;
    logic        erase_resume, status_clear, cmd_reject;
    logic [19:0] tgt_addr;

    int total = 0;
    int failed = 0;

    always #2.5 clk = ~clk;

    cmdseq_decoder u0 (
        .clk (clk), .rst_n (rst_n), .pd (pd), .wp_n (wp_n),
        .prot_mask (prot_mask), .wr_valid (wr_valid), .wr_addr (wr_addr),
        .wr_data (wr_data), .wsm_done (wsm_done), .rd_mode (rd_mode),
        .start_prog (start_prog), .start_chip_erase (start_chip_erase),
        .start_sect_erase (start_sect_erase), .start_protect (start_protect),
        .start_unprotect (start_unprotect), .erase_suspend (erase_suspend),
        .erase_resume (erase_resume), .status_clear (status_clear),
        .cmd_reject (cmd_reject), .tgt_addr (tgt_addr)
    );

    // Pulse order: reject clear resume suspend unprot prot serase cerase prog
    localparam logic [8:0] N = 9'h000, PRG = 9'h001, CER = 9'h002, SER = 9'h004;
    localparam logic [8:0] PRT = 9'h008, UNP = 9'h010, SUS = 9'h020, RES = 9'h040;
    localparam logic [8:0] CLR = 9'h080, REJ = 9'h100;
    localparam logic [1:0] MA = 2'b00, MS = 2'b01, MI = 2'b10;

    // {req[4], done[1], addr[20], data[8], pulses[9], mode[2]}
    localparam int NV = 73;
    localparam logic [43:0] VEC [NV] = '{
        {4'd2, 1'b0, 20'h05555, 8'hAA, N, MA},   // R2 identifier read
        {4'd2, 1'b0, 20'h02AAA, 8'h55, N, MA},
        {4'd2, 1'b0, 20'h05555, 8'h90, N, MI},
        {4'd1, 1'b0, 20'hF5555, 8'hAA, N, MI},   // R1 upper address bits ignored
        {4'd1, 1'b0, 20'hA2AAA, 8'h55, N, MI},
        {4'd1, 1'b0, 20'h35555, 8'hF0, N, MA},
        {4'd2, 1'b0, 20'h05555, 8'hAA, N, MA},   // R2 read status
        {4'd2, 1'b0, 20'h02AAA, 8'h55, N, MA},
        {4'd2, 1'b0, 20'h05555, 8'h70, N, MS},
        {4'd2, 1'b0, 20'h05555, 8'hAA, N, MS},   // R2 read array
        {4'd2, 1'b0, 20'h02AAA, 8'h55, N, MS},
        {4'd2, 1'b0, 20'h05555, 8'hF0, N, MA},
        {4'd3, 1'b0, 20'h05555, 8'hAA, N, MA},   // R3 program
        {4'd3, 1'b0, 20'h02AAA, 8'h55, N, MA},
        {4'd3, 1'b0, 20'h05555, 8'hA0, N, MA},
        {4'd3, 1'b0, 20'h20040, 8'h12, PRG, MS},
        {4'd7, 1'b0, 20'h05555, 8'hAA, N, MS},   // R7 array read refused while programming
        {4'd7, 1'b0, 20'h02AAA, 8'h55, N, MS},
        {4'd7, 1'b0, 20'h05555, 8'hF0, REJ, MS},
        {4'd7, 1'b0, 20'h00000, 8'hB0, REJ, MS},
        {4'd7, 1'b0, 20'h05555, 8'hAA, N, MS},   // R7 status accepted while programming
        {4'd7, 1'b0, 20'h02AAA, 8'h55, N, MS},
        {4'd7, 1'b0, 20'h05555, 8'h70, N, MS},
        {4'd8, 1'b1, 20'h05555, 8'hAA, N, MS},   // R8 status holds until array read
        {4'd8, 1'b0, 20'h02AAA, 8'h55, N, MS},
        {4'd8, 1'b0, 20'h05555, 8'hF0, N, MA},
        {4'd4, 1'b0, 20'h05555, 8'hAA, N, MA},   // R4 sector erase
        {4'd4, 1'b0, 20'h02AAA, 8'h55, N, MA},
        {4'd4, 1'b0, 20'h05555, 8'h80, N, MA},
        {4'd4, 1'b0, 20'h05555, 8'hAA, N, MA},
        {4'd4, 1'b0, 20'h02AAA, 8'h55, N, MA},
        {4'd4, 1'b0, 20'h50000, 8'h30, SER, MS},
        {4'd6, 1'b0, 20'h12345, 8'hB0, SUS, MS}, // R6 suspend in sector erase
        {4'd7, 1'b0, 20'h05555, 8'hAA, N, MS},   // R7 array read allowed in suspend
        {4'd7, 1'b0, 20'h02AAA, 8'h55, N, MS},
        {4'd7, 1'b0, 20'h05555, 8'hF0, N, MA},
        {4'd7, 1'b0, 20'h05555, 8'hAA, N, MA},   // R7 identifier refused in suspend
        {4'd7, 1'b0, 20'h02AAA, 8'h55, N, MA},
        {4'd7, 1'b0, 20'h05555, 8'h90, REJ, MA},
        {4'd6, 1'b0, 20'h0ABCD, 8'hD0, RES, MS}, // R6 resume
        {4'd4, 1'b1, 20'h05555, 8'hAA, N, MS},   // R4 chip erase
        {4'd4, 1'b0, 20'h02AAA, 8'h55, N, MS},
        {4'd4, 1'b0, 20'h05555, 8'h80, N, MS},
        {4'd4, 1'b0, 20'h05555, 8'hAA, N, MS},
        {4'd4, 1'b0, 20'h02AAA, 8'h55, N, MS},
        {4'd4, 1'b0, 20'h05555, 8'h10, CER, MS},
        {4'd6, 1'b0, 20'h00000, 8'hB0, REJ, MS}, // R6 no suspend in chip erase
        {4'd5, 1'b1, 20'h05555, 8'hAA, N, MS},   // R5 protect
        {4'd5, 1'b0, 20'h02AAA, 8'h55, N, MS},
        {4'd5, 1'b0, 20'h05555, 8'h60, N, MS},
        {4'd5, 1'b0, 20'h05555, 8'hAA, N, MS},
        {4'd5, 1'b0, 20'h02AAA, 8'h55, N, MS},
        {4'd5, 1'b0, 20'h70000, 8'h20, PRT, MS},
        {4'd5, 1'b1, 20'h05555, 8'hAA, N, MS},   // R5 unprotect
        {4'd5, 1'b0, 20'h02AAA, 8'h55, N, MS},
        {4'd5, 1'b0, 20'h05555, 8'h60, N, MS},
        {4'd5, 1'b0, 20'h05555, 8'hAA, N, MS},
        {4'd5, 1'b0, 20'h02AAA, 8'h55, N, MS},
        {4'd5, 1'b0, 20'h70000, 8'h40, UNP, MS},
        {4'd2, 1'b1, 20'h05555, 8'hAA, N, MS},   // R2 clear status keeps mode
        {4'd2, 1'b0, 20'h02AAA, 8'h55, N, MS},
        {4'd2, 1'b0, 20'h05555, 8'h50, CLR, MS},
        {4'd11, 1'b0, 20'h05555, 8'hAA, N, MS},  // R11 repeated first key restarts
        {4'd11, 1'b0, 20'h05555, 8'hAA, N, MS},
        {4'd11, 1'b0, 20'h02AAA, 8'h55, N, MS},
        {4'd11, 1'b0, 20'h05555, 8'hF0, N, MA},
        {4'd11, 1'b0, 20'h05555, 8'hAA, N, MA},  // R11 wrong second key drops sequence
        {4'd11, 1'b0, 20'h01234, 8'h55, N, MA},
        {4'd11, 1'b0, 20'h05555, 8'h70, N, MA},
        {4'd6, 1'b0, 20'h00000, 8'hD0, REJ, MA}, // R6 resume outside suspend
        {4'd2, 1'b0, 20'h05555, 8'hAA, N, MA},   // R2 unknown byte does nothing
        {4'd2, 1'b0, 20'h02AAA, 8'h55, N, MA},
        {4'd2, 1'b0, 20'h05555, 8'h33, N, MA}
    };

    function automatic logic [8:0] pulses_now();
        return {cmd_reject, status_clear, erase_resume, erase_suspend,
                start_unprotect, start_protect, start_sect_erase,
                start_chip_erase, start_prog};
    endfunction

    task automatic wr(input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        wsm_done = 1'b1;
        @(negedge clk);
        wsm_done = 1'b0;
    endtask

    task automatic chk(input string req, input logic [8:0] e_p, input logic [1:0] e_m);
        total++;
        if (pulses_now() !== e_p || rd_mode !== e_m) begin
            failed++;
            $display("FAIL %s pulses=%h mode=%0d expected pulses=%h mode=%0d",
                     req, pulses_now(), rd_mode, e_p, e_m);
        end
    endtask

    task automatic chk_tgt(input string req, input logic [19:0] e_a);
        total++;
        if (tgt_addr !== e_a) begin
            failed++;
            $display("FAIL %s tgt_addr=%h expected %h", req, tgt_addr, e_a);
        end
    endtask

    task automatic keys();
        wr(20'h05555, 8'hAA);
        wr(20'h02AAA, 8'h55);
    endtask

    task automatic six(input logic [7:0] setup, input logic [19:0] a, input logic [7:0] d);
        keys();
        wr(20'h05555, setup);
        keys();
        wr(a, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failed++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", total, failed);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset state", N, MA);
        chk_tgt("R9 reset target", 20'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][39]) done_pulse();
            wr(VEC[i][38:19], VEC[i][18:11]);
            chk($sformatf("R%0d vector %0d", VEC[i][43:40], i), VEC[i][10:2], VEC[i][1:0]);
        end

        // R5 lock update refused with write-protect low
        wp_n = 1'b0;
        six(8'h60, 20'h10000, 8'h20);
        chk("R5 protect with wp_n low", REJ, MA);
        wp_n = 1'b1;

        // R10 sector erase and program to protected sector 3
        six(8'h80, 20'h30000, 8'h30);
        chk("R10 erase protected sector", REJ, MA);
        keys();
        wr(20'h05555, 8'hA0);
        wr(20'h30100, 8'h77);
        chk("R10 program protected sector", REJ, MA);
        keys();
        wr(20'h05555, 8'h90);
        chk("R10 context stays idle", N, MI);

        // R4 target latch, R11 suspend inside a sequence
        six(8'h80, 20'h61234, 8'h30);
        chk("R4 sector erase start", SER, MS);
        chk_tgt("R4 sector target", 20'h61234);
        keys();
        wr(20'h00000, 8'hB0);
        chk("R11 suspend breaks sequence", SUS, MS);

        // R9 power-down clears mode and context
        @(negedge clk);
        pd = 1'b1;
        @(negedge clk);
        pd = 1'b0;
        chk("R9 power-down array mode", N, MA);
        keys();
        wr(20'h05555, 8'h90);
        chk("R9 context idle after power-down", N, MI);

        // R3 program target latch
        keys();
        wr(20'h05555, 8'hA0);
        wr(20'h200C0, 8'h5A);
        chk("R3 program start", PRG, MS);
        chk_tgt("R3 program target", 20'h200C0);
        done_pulse();

        // R9 reset mid-sequence drops partial keys
        wr(20'h05555, 8'hAA);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R9 reset returns array mode", N, MA);
        wr(20'h02AAA, 8'h55);
        wr(20'h05555, 8'h70);
        chk("R9 stale sequence not completed", N, MA);

        $display("[TB] %0d tests run, %0d failed", total, failed);
        $finish;
    end

endmodule